// File: doc/BRIEF.md
# Interrupt Source Gateway Array

This block turns a set of raw interrupt wires into a vector of pending flags, one gateway per source. Each source is set up by its own mode bit as either rising-edge sensitive or level sensitive. When a gateway sees an event, it raises that source's pending flag. It then locks the source until the interrupt has been serviced.

Service happens in two steps, both driven from outside by the logic that arbitrates between sources. A claim strobe carries a source identifier and drops the pending flag of that source. A later complete strobe carries the same identifier and unlocks the source so that it can accept new events. Source `k` (bit `k` of the input vector) has identifier `k+1`. Identifier 0 means "no source".

Edges that arrive while a source is locked are lost and are not counted. A level source that drops its request cannot withdraw a pending flag that is already raised.

Top module: `irq_gateway_array`

## Requirements
- R1: After reset every pending flag is 0, every source is unlocked and the stored previous input sample is 0.
- R2: A source with mode bit 1 (edge) that is unlocked and sees its input go 0 to 1 raises its pending flag at the next clock edge. An input that simply stays high does not raise it again.
- R3: A source with mode bit 0 (level) that is unlocked and has its input high at a clock edge raises its pending flag at that edge.
- R4: A claim strobe whose identifier equals `k+1` clears the pending flag of source `k` at the next edge, whatever the input level is.
- R5: From the edge that raises a pending flag until a complete for that source takes effect, new events on that source are ignored. This covers the case where the flag has already been claimed. Edges in that window are not remembered afterwards.
- R6: A pending flag that is raised stays at 1 when the level input falls. Only a claim clears it.
- R7: A complete strobe with identifier `k+1` unlocks source `k` at its clock edge. Events are accepted again from the following edge on, so a level input that is still high raises the flag one cycle after the complete edge.
- R8: A claim or complete with identifier 0, or with an identifier above the source count, changes nothing.
- R9: A claim or complete acts only on the source it names. Every other source's pending flag and lock are unchanged.
- R10: If an unlocked source accepts an event in the same cycle as a claim naming it, the event wins and the pending flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srcIn | input | NumSrc | Raw interrupt inputs, bit k is source k |
| edgeMode | input | NumSrc | Per-source mode: 1 edge, 0 level |
| claimValid | input | 1 | One-cycle claim strobe |
| claimId | input | IdW | Identifier being claimed (k+1) |
| completeValid | input | 1 | One-cycle complete strobe |
| completeId | input | IdW | Identifier being completed (k+1) |
| pending | output | NumSrc | Pending flag per source |

## Verification
Every result appears one register stage after its cause. An input event, a claim or a complete sampled at edge N shows up in `pending` right after edge N. The single exception is a level input that is still high after a complete: its re-raise shows up one edge later, because the unlock must first land before the event counts. The bench drives stimulus 2 ns after a rising edge and reads outputs 2 ns after the next rising edge. It also compares the whole pending vector with a behavioural model at every falling edge, so each check sits inside the cycle in which its result is due.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;
  // Per-source strobes passed from the identifier decoder to the gateways.
  typedef struct packed {
    logic claim;
    logic complete;
  } gwStrobe_t;
endpackage

// File: rtl/irq_gw_decode.sv
module irq_gw_decode
  import irq_gw_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int IdW    = $clog2(NumSrc + 1)
) (
  input  logic                    claimValid,
  input  logic [IdW-1:0]          claimId,
  input  logic                    completeValid,
  input  logic [IdW-1:0]          completeId,
  output gwStrobe_t [NumSrc-1:0]  strb
);
  // Source k answers to identifier k+1. Id 0 and ids above NumSrc match nothing.
  for (genvar k = 0; k < NumSrc; k++) begin : g_dec
    localparam logic [IdW-1:0] MyId = IdW'(k + 1);
    always_comb begin
      strb[k].claim    = claimValid    && (claimId    == MyId);
      strb[k].complete = completeValid && (completeId == MyId);
    end
  end
endmodule

// File: rtl/irq_gw_datapath.sv
module irq_gw_datapath
  import irq_gw_pkg::*;
#(
  parameter int NumSrc = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NumSrc-1:0]       srcIn,
  input  logic [NumSrc-1:0]       edgeMode,
  input  gwStrobe_t [NumSrc-1:0]  strb,
  output logic [NumSrc-1:0]       pending
);
  logic [NumSrc-1:0] prevSample;
  logic [NumSrc-1:0] active;
  logic [NumSrc-1:0] event_;
  logic [NumSrc-1:0] accept;

  for (genvar k = 0; k < NumSrc; k++) begin : g_gw
    always_comb begin
      event_[k] = edgeMode[k] ? (srcIn[k] & ~prevSample[k]) : srcIn[k];
      accept[k] = event_[k] & ~active[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevSample[k] <= 1'b0;
        active[k]     <= 1'b0;
        pending[k]    <= 1'b0;
      end else begin
        prevSample[k] <= srcIn[k];
        if (accept[k]) begin
          active[k]  <= 1'b1;
          pending[k] <= 1'b1;
        end else begin
          if (strb[k].complete) active[k]  <= 1'b0;
          if (strb[k].claim)    pending[k] <= 1'b0;
        end
      end
    end

    // R3: an unlocked level source that is high must become pending.
    p_level_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!edgeMode[k] && srcIn[k] && !active[k]) |=> pending[k]);

    // R4: a claim on a locked source leaves its flag clear.
    p_claim_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb[k].claim && active[k]) |=> !pending[k]);

    // R5: a flag can only rise while the source was unlocked.
    p_rise_needs_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending[k]) |-> !$past(active[k]));

    // R6: without a claim a raised flag stays raised.
    p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[k] && !strb[k].claim) |=> pending[k]);

    // R7: the lock is released only by a complete naming this source.
    p_unlock_by_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active[k]) |-> $past(strb[k].complete));
  end
endmodule

// File: rtl/irq_gateway_array.sv
module irq_gateway_array
  import irq_gw_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int IdW    = $clog2(NumSrc + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NumSrc-1:0] srcIn,
  input  logic [NumSrc-1:0] edgeMode,
  input  logic              claimValid,
  input  logic [IdW-1:0]    claimId,
  input  logic              completeValid,
  input  logic [IdW-1:0]    completeId,
  output logic [NumSrc-1:0] pending
);
  gwStrobe_t [NumSrc-1:0] strb;

  irq_gw_decode #(.NumSrc(NumSrc), .IdW(IdW)) i_decode (
    .claimValid   (claimValid),
    .claimId      (claimId),
    .completeValid(completeValid),
    .completeId   (completeId),
    .strb         (strb)
  );

  irq_gw_datapath #(.NumSrc(NumSrc)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .srcIn   (srcIn),
    .edgeMode(edgeMode),
    .strb    (strb),
    .pending (pending)
  );

  // R8: an invalid identifier must leave every flag without a falling edge.
  p_bad_id_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (claimValid && ((claimId == '0) || (int'(claimId) > NumSrc)))
      |=> ($past(pending) & ~pending) == '0);
endmodule

// File: tb/test_irq_gateway_array.sv
module test_irq_gateway_array;
  localparam int NumSrc = 8;
  localparam int IdW    = $clog2(NumSrc + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NumSrc-1:0] srcIn = '0;
  logic [NumSrc-1:0] edgeMode = 8'b0000_1111;
  logic              claimValid = 1'b0;
  logic [IdW-1:0]    claimId = '0;
  logic              completeValid = 1'b0;
  logic [IdW-1:0]    completeId = '0;
  logic [NumSrc-1:0] pending;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_gateway_array #(.NumSrc(NumSrc)) i_irq_gateway_array (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .edgeMode(edgeMode),
    .claimValid(claimValid), .claimId(claimId),
    .completeValid(completeValid), .completeId(completeId),
    .pending(pending)
  );

  // Behavioural reference model: locked-source bookkeeping per identifier.
  bit mPend [NumSrc];
  bit mLock [NumSrc];
  bit mLast [NumSrc];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mPend[s]) begin mPend[s] = 0; mLock[s] = 0; mLast[s] = 0; end
    end else begin
      foreach (mPend[s]) begin
        bit hit;
        bit claimed;
        bit done;
        claimed = claimValid    && (int'(claimId)    == s + 1);
        done    = completeValid && (int'(completeId) == s + 1);
        if (edgeMode[s]) hit = srcIn[s] && !mLast[s];
        else             hit = srcIn[s];
        if (hit && !mLock[s]) begin
          mPend[s] = 1; mLock[s] = 1;
        end else begin
          if (claimed) mPend[s] = 0;
          if (done)    mLock[s] = 0;
        end
        mLast[s] = srcIn[s];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < NumSrc; s++) begin
        nChecks++;
        if (pending[s] !== mPend[s]) begin
          nFail++;
          $display("FAIL R2/R3/R4/R5/R6/R7/R9/R10 model src %0d: actual %b expected %b",
                   s, pending[s], mPend[s]);
        end
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(string req, int s, bit exp);
    nChecks++;
    if (pending[s] !== exp) begin
      nFail++;
      $display("FAIL %s src %0d: actual %b expected %b", req, s, pending[s], exp);
    end
  endtask

  task automatic claim(int id);
    claimValid = 1'b1; claimId = IdW'(id);
    cyc();
    claimValid = 1'b0; claimId = '0;
  endtask

  task automatic complete(int id);
    completeValid = 1'b1; completeId = IdW'(id);
    cyc();
    completeValid = 1'b0; completeId = '0;
  endtask

  initial begin
    fork
      begin
        #1000000;
        nFail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
        $finish;
      end
    join_none

    cyc(3);
    rst_n = 1'b1;
    #1;
    nChecks++;
    if (pending !== '0) begin
      nFail++;
      $display("FAIL R1 reset: actual %b expected 0", pending);
    end

    // R2: edge source 0
    srcIn[0] = 1; cyc(); chk("R2 edge raise", 0, 1);
    srcIn[0] = 0; cyc(); srcIn[0] = 1; cyc();
    claim(1); chk("R4 claim clears", 0, 0);
    srcIn[0] = 0; cyc(); srcIn[0] = 1; cyc();
    chk("R5 edge ignored while locked", 0, 0);
    complete(1); cyc(2);
    chk("R5 locked edge not remembered", 0, 0);
    chk("R2 steady high no retrigger", 0, 0);
    srcIn[0] = 0; cyc(); srcIn[0] = 1; cyc();
    chk("R7 edge rearmed", 0, 1);
    claim(1); complete(1); srcIn[0] = 0;

    // R3 / R6: level source 4
    srcIn[4] = 1; cyc(); chk("R3 level raise", 4, 1);
    srcIn[4] = 0; cyc(2); chk("R6 level drop holds", 4, 1);
    srcIn[4] = 1;
    claim(5); chk("R4 claim with input high", 4, 0);
    cyc(3); chk("R5 level ignored while locked", 4, 0);
    complete(5); chk("R7 complete edge not yet rearmed", 4, 0);
    cyc(); chk("R7 level re-raise one cycle later", 4, 1);
    srcIn[4] = 0; claim(5); complete(5);

    // R8 / R9: sources 1 and 2
    srcIn[1] = 1; srcIn[2] = 1; cyc();
    chk("R9 setup", 1, 1); chk("R9 setup", 2, 1);
    claim(0);  chk("R8 id zero claim", 1, 1);
    claim(12); chk("R8 out of range claim", 1, 1);
    chk("R8 out of range claim", 2, 1);
    claim(2); chk("R4 claim src1", 1, 0); chk("R9 neighbour kept", 2, 1);
    complete(0); complete(15);
    srcIn[1] = 0; cyc(); srcIn[1] = 1; cyc();
    chk("R8 bad complete keeps lock", 1, 0);
    complete(2); srcIn[1] = 0; cyc(); srcIn[1] = 1; cyc();
    chk("R7 src1 rearmed", 1, 1);
    chk("R9 neighbour untouched by complete", 2, 1);

    // R10: level source 6, event and claim together
    srcIn[6] = 1; claimValid = 1'b1; claimId = IdW'(7);
    cyc(); claimValid = 1'b0; claimId = '0;
    chk("R10 event beats claim", 6, 1);

    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule